// File: doc/BRIEF.md
# Link Rate and Lane Fallback Unit

When a serial display link does not complete training, the link controller needs a slower or narrower configuration to try next. This unit works out that configuration. It takes the rate code and lane count that just failed, plus the highest rate and the widest lane count the sink supports. It returns the next configuration to try and a flag that says whether a usable step exists.

A step does not simply lower the rate. A wide link at the top rate first gives up lanes. Only when it is down to a single lane does it fall to the middle rate, and then it regains the full lane width. The middle rate drops to the lowest rate with its lane count kept. At the lowest rate the lane count halves, and if the sink allows it the rate moves back up to the middle value.

The controller pulses `start` for one cycle. Two edges later the unit pulses `done` for one cycle and presents the result. The unit saves the configuration it was given at `start`. If no usable step exists, it puts that saved configuration back on the outputs, so the link can be restored to its previous setting.

Top module: `link_fallback_unit`

## Requirements
- R1: Rate codes are 2 bits: 2'b01 is the lowest rate (1.62 Gbps per lane), 2'b10 the middle rate (2.7 Gbps), 2'b11 the top rate (5.4 Gbps), and 2'b00 is not a recognised rate. Lane counts are 3-bit binary numbers, with 1, 2 and 4 as the intended values.
- R2: At the top rate with more than one lane, the result keeps the top rate and halves the lane count.
- R3: At the top rate with exactly one lane, the result is the middle rate, with the lane count set to the sink's maximum lane count.
- R4: At the middle rate, the result is the lowest rate, with the lane count unchanged.
- R5: At the lowest rate, the lane count halves. The rate becomes the middle rate if the maximum rate code is above the lowest-rate code; otherwise it stays at the lowest rate.
- R6: An unrecognised rate code (2'b00) gives a failed step, with `link_ok` = 0.
- R7: A step whose resulting lane count is zero fails, with `link_ok` = 0. A step reported as successful never shows zero lanes.
- R8: On a failed step, the outputs show the rate and lane count that were sampled at the accepted `start`.
- R9: A `start` sampled high while the unit is idle is accepted. `done` is then high for exactly one cycle, at the second rising edge after acceptance, and the results are valid from that edge.
- R10: A `start` sampled on the edge right after an accepted one is ignored. Outputs do not change except on the edge that raises `done`, and changes on the current-configuration inputs without `start` have no effect.
- R11: After reset, `new_rate` = 2'b00, `new_lanes` = 0, `link_ok` = 0 and `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request for one fallback step |
| cur_rate | input | 2 | Rate code that failed training |
| cur_lanes | input | 3 | Lane count that failed training |
| max_rate | input | 2 | Highest rate code the sink supports |
| max_lanes | input | 3 | Widest lane count the sink supports |
| new_rate | output | 2 | Next rate code to try, or the saved one on failure |
| new_lanes | output | 3 | Next lane count to try, or the saved one on failure |
| link_ok | output | 1 | 1 when a usable lower configuration was found |
| done | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The step is tried from every rate code:
- The top rate is tried at four, two and one lanes, which separates the lane-halving branch from the branch that drops the rate and refills the lanes.
- The single-lane top-rate case is run with two different maximum lane counts, to show that the refill takes its width from the sink and not from the input.
- The lowest rate is run with a low maximum rate and with a higher one, which exposes the conditional move back up to the middle rate.
- A one-lane lowest-rate input and the unrecognised code both check that the saved configuration is restored.
- A back-to-back `start` and input changes with no `start` show that the outputs change only on the edge that raises `done`.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int RATE_W  = 2;
  localparam int LANES_W = 3;

  typedef logic [RATE_W-1:0]  rate_t;
  typedef logic [LANES_W-1:0] lanes_t;

  localparam rate_t RATE_BAD  = 2'b00;
  localparam rate_t RATE_LOW  = 2'b01;
  localparam rate_t RATE_MID  = 2'b10;
  localparam rate_t RATE_HIGH = 2'b11;

  typedef struct packed {
    rate_t  rate;
    lanes_t lanes;
  } link_cfg_t;

  typedef struct packed {
    link_cfg_t cfg;
    logic      ok;
  } step_res_t;

  function automatic lanes_t halve_lanes(input lanes_t n);
    return n >> 1;
  endfunction

  // One fallback step; ok clears on unknown rate or zero lanes.
  function automatic step_res_t fallback_step(input link_cfg_t cur,
                                              input rate_t max_rate,
                                              input lanes_t max_lanes);
    step_res_t r;
    r.cfg = cur;
    r.ok  = 1'b1;
    case (cur.rate)
      RATE_HIGH: begin
        if (cur.lanes == lanes_t'(1)) begin
          r.cfg.rate  = RATE_MID;
          r.cfg.lanes = max_lanes;
        end else begin
          r.cfg.lanes = halve_lanes(cur.lanes);
        end
      end
      RATE_MID: r.cfg.rate = RATE_LOW;
      RATE_LOW: begin
        if (max_rate > RATE_LOW) r.cfg.rate = RATE_MID;
        r.cfg.lanes = halve_lanes(cur.lanes);
      end
      default: r.ok = 1'b0;
    endcase
    if (r.cfg.lanes == '0) r.ok = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/lfb_ctrl.sv
module lfb_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  assign accept = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      busy <= accept;
      done <= busy;
    end
  end
endmodule

// File: rtl/lfb_snapshot.sv
module lfb_snapshot
  import lfb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  link_cfg_t cur_cfg,
  output link_cfg_t saved_cfg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      saved_cfg <= '0;
    else if (accept) saved_cfg <= cur_cfg;
  end
endmodule

// File: rtl/lfb_step.sv
module lfb_step
  import lfb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      accept,
  input  link_cfg_t cur_cfg,
  input  rate_t     max_rate,
  input  lanes_t    max_lanes,
  output step_res_t cand
);
  step_res_t next_res;
  assign next_res = fallback_step(cur_cfg, max_rate, max_lanes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cand <= '0;
    else if (accept) cand <= next_res;
  end
endmodule

// File: rtl/lfb_result.sv
module lfb_result
  import lfb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      commit,
  input  step_res_t cand,
  input  link_cfg_t saved_cfg,
  output link_cfg_t out_cfg,
  output logic      out_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cfg <= '0;
      out_ok  <= 1'b0;
    end else if (commit) begin
      out_cfg <= cand.ok ? cand.cfg : saved_cfg;
      out_ok  <= cand.ok;
    end
  end
endmodule

// File: rtl/link_fallback_unit.sv
module link_fallback_unit
  import lfb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATE_W-1:0]  cur_rate,
  input  logic [LANES_W-1:0] cur_lanes,
  input  logic [RATE_W-1:0]  max_rate,
  input  logic [LANES_W-1:0] max_lanes,
  output logic [RATE_W-1:0]  new_rate,
  output logic [LANES_W-1:0] new_lanes,
  output logic               link_ok,
  output logic               done
);
  logic      accept;
  logic      busy;
  link_cfg_t cur_cfg;
  link_cfg_t saved_cfg;
  link_cfg_t out_cfg;
  step_res_t cand;

  // Named wires for the checker
  rate_t  saved_rate_w;
  lanes_t saved_lanes_w;

  assign cur_cfg.rate  = cur_rate;
  assign cur_cfg.lanes = cur_lanes;

  lfb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .accept(accept), .busy(busy), .done(done)
  );

  lfb_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cur_cfg(cur_cfg), .saved_cfg(saved_cfg)
  );

  lfb_step u_step (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cur_cfg(cur_cfg),
    .max_rate(max_rate), .max_lanes(max_lanes), .cand(cand)
  );

  lfb_result u_res (
    .clk(clk), .rst_n(rst_n), .commit(busy), .cand(cand),
    .saved_cfg(saved_cfg), .out_cfg(out_cfg), .out_ok(link_ok)
  );

  assign new_rate      = out_cfg.rate;
  assign new_lanes     = out_cfg.lanes;
  assign saved_rate_w  = saved_cfg.rate;
  assign saved_lanes_w = saved_cfg.lanes;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker
  import lfb_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   accept,
  input logic   done,
  input rate_t  new_rate,
  input lanes_t new_lanes,
  input logic   link_ok,
  input rate_t  saved_rate_w,
  input lanes_t saved_lanes_w
);
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_rate) && $stable(new_lanes) && $stable(link_ok)));

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !link_ok) |-> (new_rate == saved_rate_w && new_lanes == saved_lanes_w));

  p_ok_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && link_ok) |-> (new_lanes != '0));

  p_ok_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && link_ok) |-> (new_rate != RATE_BAD));
endmodule

bind link_fallback_unit lfb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
  .new_rate(new_rate), .new_lanes(new_lanes), .link_ok(link_ok),
  .saved_rate_w(saved_rate_w), .saved_lanes_w(saved_lanes_w)
);

// File: tb/sim_link_fallback_unit.sv
module sim_link_fallback_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] cur_rate = 2'b00;
  logic [2:0] cur_lanes = 3'd0;
  logic [1:0] max_rate = 2'b00;
  logic [2:0] max_lanes = 3'd0;
  logic [1:0] new_rate;
  logic [2:0] new_lanes;
  logic       link_ok;
  logic       done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  link_fallback_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cur_rate(cur_rate), .cur_lanes(cur_lanes),
    .max_rate(max_rate), .max_lanes(max_lanes),
    .new_rate(new_rate), .new_lanes(new_lanes),
    .link_ok(link_ok), .done(done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Bench model of one step: {rate, lanes, ok}
  function automatic logic [5:0] model(input logic [1:0] r, input logic [2:0] n,
                                        input logic [1:0] mr, input logic [2:0] ml);
    logic [1:0] er; logic [2:0] en; logic eok;
    er = r; en = n; eok = 1'b1;
    if (r == 2'b11 && n > 3'd1)       en = n / 2;
    else if (r == 2'b11)              begin er = 2'b10; en = ml; end
    else if (r == 2'b10)              er = 2'b01;
    else if (r == 2'b01)              begin en = n / 2; er = (mr >= 2'b10) ? 2'b10 : 2'b01; end
    else                              eok = 1'b0;
    if (en == 3'd0) eok = 1'b0;
    if (!eok) begin er = r; en = n; end
    return {er, en, eok};
  endfunction

  task automatic run_step(input string req, input logic [1:0] r, input logic [2:0] n,
                          input logic [1:0] mr, input logic [2:0] ml);
    logic [5:0] e;
    e = model(r, n, mr, ml);
    @(negedge clk);
    cur_rate = r; cur_lanes = n; max_rate = mr; max_lanes = ml; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(req, "done early", int'(done), 0);
    @(negedge clk);
    check(req, "done", int'(done), 1);
    check(req, "rate", int'(new_rate), int'(e[5:4]));
    check(req, "lanes", int'(new_lanes), int'(e[3:1]));
    check(req, "ok", int'(link_ok), int'(e[0]));
    @(negedge clk);
    check(req, "done pulse end", int'(done), 0);
  endtask

  task automatic t_reset;
    check("R11", "rate", int'(new_rate), 0);
    check("R11", "lanes", int'(new_lanes), 0);
    check("R11", "ok", int'(link_ok), 0);
    check("R11", "done", int'(done), 0);
  endtask

  task automatic t_busy_ignore;
    @(negedge clk);
    cur_rate = 2'b10; cur_lanes = 3'd4; max_rate = 2'b11; max_lanes = 3'd4; start = 1'b1;
    @(negedge clk);
    cur_rate = 2'b11; cur_lanes = 3'd4;  // second start while busy: R10
    @(negedge clk);
    start = 1'b0;
    check("R10", "done", int'(done), 1);
    check("R10", "rate", int'(new_rate), 1);
    check("R10", "lanes", int'(new_lanes), 4);
    @(negedge clk);
    check("R10", "no second done", int'(done), 0);
    @(negedge clk);
    check("R10", "no second done later", int'(done), 0);
    check("R10", "rate held", int'(new_rate), 1);
    check("R10", "lanes held", int'(new_lanes), 4);
  endtask

  task automatic t_hold;
    @(negedge clk);
    cur_rate = 2'b11; cur_lanes = 3'd2; max_lanes = 3'd2;
    repeat (4) @(negedge clk);
    check("R10", "hold done", int'(done), 0);
    check("R10", "hold rate", int'(new_rate), 1);
    check("R10", "hold lanes", int'(new_lanes), 4);
    check("R10", "hold ok", int'(link_ok), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run_step("R2", 2'b11, 3'd4, 2'b11, 3'd4);
    run_step("R2", 2'b11, 3'd2, 2'b11, 3'd4);
    run_step("R3", 2'b11, 3'd1, 2'b11, 3'd4);
    run_step("R3", 2'b11, 3'd1, 2'b11, 3'd2);
    run_step("R4", 2'b10, 3'd4, 2'b11, 3'd4);
    run_step("R4", 2'b10, 3'd1, 2'b10, 3'd4);
    run_step("R5", 2'b01, 3'd4, 2'b11, 3'd4);
    run_step("R5", 2'b01, 3'd4, 2'b01, 3'd4);
    run_step("R5", 2'b01, 3'd2, 2'b10, 3'd2);
    run_step("R7", 2'b01, 3'd1, 2'b11, 3'd4);
    run_step("R6", 2'b00, 3'd4, 2'b11, 3'd4);
    run_step("R8", 2'b00, 3'd2, 2'b10, 3'd2);
    run_step("R1", 2'b11, 3'd4, 2'b11, 3'd4);
    t_busy_ignore();
    t_hold();
    run_step("R9", 2'b10, 3'd2, 2'b10, 3'd2);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule